// File: doc/BRIEF.md
# Delay-Line Period Calibration Sequencer

This block is a hardware sequencer that tunes an external tapped delay line. It searches for the setting at which one full input-clock period has passed through the line. The line returns a length vector with one bit per phase tap, plus a flag that says the vector is valid. For each tap, the sequencer steps the unit delay upward from zero. It waits for the valid flag after every write, and watches that tap's bit go high and then low again. The first tap that shows a full period gives the result: the unit value at that point, and a select value one above the tap index.

Once the sweep is over, the sequencer writes the chosen setting into the line in four steps: both enables off, both enables on, write the fields, then sampler enable off with the line still enabled. The same four steps also serve a direct-configure request, which applies a select and unit pair supplied by the caller without any sweep. A disable request turns the line off. A wait that exceeds a tick budget aborts calibration and reports a timeout.

Top module: `dline_cal`

## Requirements
- R1: After reset, lineEn, sampEn, cfgWr, busy, done, timeout and notFound are 0, and selOut and unitOut are 0.
- R2: A startCal seen while idle sets busy, lineEn and sampEn in the following cycle.
- R3: Each sweep write puts NUM_SEL on selOut. Within one tap index, unitOut starts at 0 and rises by one on each write. Every write is marked by a one-cycle cfgWr pulse.
- R4: After each write the sequencer samples lenVec only once lenValid is 1. Ticks are counted only while waiting. Calibration aborts when TMO_TICKS ticks pass without lenValid: a one-cycle timeout pulse, busy falls, and done stays low. Cycles with tick low do not count toward the budget.
- R5: For tap index k, lenVec bit k must first read 1 and later read 0 for the sweep of that index to detect a full period. The unit value of the step that reads 0 is the detected value.
- R6: Only the first detected period is kept: calSel = k+1 and calUnit = the detected unit. Detections on later indices do not change them. All indices 0..NUM_SEL-1 are swept anyway.
- R7: The apply sequence drives lineEn and sampEn both to 0, then both to 1, then writes selOut and unitOut, then drops sampEn while lineEn stays 1. done is a one-cycle pulse in the cycle in which sampEn has fallen.
- R8: cfgWr is only ever high while lineEn and sampEn are both 1.
- R9: A startCfg seen while idle applies cfgSel and cfgUnit with exactly one write and no sweep. It does not change calSel, calUnit or notFound.
- R10: A disableReq seen while idle clears lineEn and sampEn in the next cycle. disableReq takes priority over startCal, and startCal takes priority over startCfg.
- R11: busy stays 1 from the start until the cycle of done or timeout. startCal and startCfg have no effect while busy.
- R12: If no index detects a full period, notFound is set, calSel and calUnit are 0, and select 0 with unit 0 is applied.
- R13: The sweep of an index ends at unit 2^UNIT_W-1 if no full period has been detected by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase tick for the wait budget |
| startCal | input | 1 | Begin calibration sweep |
| startCfg | input | 1 | Begin direct apply of cfgSel/cfgUnit |
| cfgSel | input | $clog2(NUM_SEL+1) | Caller select for direct apply |
| cfgUnit | input | UNIT_W | Caller unit value for direct apply |
| disableReq | input | 1 | Turn the line off (idle only) |
| lenValid | input | 1 | Length vector valid from the line |
| lenVec | input | NUM_SEL | Sampled length bits, one per tap |
| lineEn | output | 1 | Delay line enable |
| sampEn | output | 1 | Sampler enable; gates writes |
| cfgWr | output | 1 | One-cycle write strobe for selOut/unitOut |
| selOut | output | $clog2(NUM_SEL+1) | Select field to the line |
| unitOut | output | UNIT_W | Unit delay field to the line |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the apply sequence ends |
| timeout | output | 1 | One-cycle pulse on wait-budget abort |
| notFound | output | 1 | Last calibration found no full period |
| calSel | output | $clog2(NUM_SEL+1) | Calibrated select (index+1) |
| calUnit | output | UNIT_W | Calibrated unit value |

## Verification
The bench builds the block with NUM_SEL=4, UNIT_W=5 and TMO_TICKS=16. With four taps, a sweep can include an early hit, a later hit that must not replace it, a tap that never goes high, and a tap that stays high until the last unit, all in a few hundred cycles. The 5-bit unit field makes the end-of-range stop (unit 31) and the not-found path cheap to reach. The budget of 16 ticks allows the timeout to be hit exactly, checked against a line latency just under it, and checked with the tick held low so that the wait outlasts the budget in cycles without aborting.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic initSweep;   // enables on, sweep indices cleared
    logic loadCfg;     // capture caller select/unit
    logic progSweep;   // write max select + current unit
    logic tmoCount;    // one tick spent waiting
    logic markHigh;    // half period high seen
    logic recordHit;   // full period seen on this index
    logic stepUnit;    // next unit value
    logic stepSel;     // next tap index
    logic pickResult;  // choose setting to apply
    logic ctlOff;      // both enables low
    logic ctlOn;       // both enables high
    logic progApply;   // write chosen setting
    logic sampOff;     // sampler enable low
  } dlcal_strb_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_SETTLE, ST_WAIT, ST_OFF, ST_ON, ST_WR, ST_DROP
  } dlcal_state_t;
endpackage

// File: rtl/dlcal_dp.sv
module dlcal_dp
  import dlcal_pkg::*;
#(
  parameter int NUM_SEL   = 12,
  parameter int UNIT_W    = 7,
  parameter int TMO_TICKS = 255
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dlcal_strb_t                     strb,
  input  logic [$clog2(NUM_SEL+1)-1:0]    cfgSel,
  input  logic [UNIT_W-1:0]               cfgUnit,
  input  logic [NUM_SEL-1:0]              lenVec,
  output logic                            bitNow,
  output logic                            tuning,
  output logic                            unitLast,
  output logic                            selLast,
  output logic                            tmoHit,
  output logic                            lineEn,
  output logic                            sampEn,
  output logic                            cfgWr,
  output logic [$clog2(NUM_SEL+1)-1:0]    selOut,
  output logic [UNIT_W-1:0]               unitOut,
  output logic                            notFound,
  output logic [$clog2(NUM_SEL+1)-1:0]    calSel,
  output logic [UNIT_W-1:0]               calUnit
);
  localparam int SEL_W = $clog2(NUM_SEL + 1);
  localparam int TMO_W = $clog2(TMO_TICKS + 1);

  logic [SEL_W-1:0]  selIdx, hitSel, applySel, effSel;
  logic [UNIT_W-1:0] unitIdx, hitUnit, applyUnit, effUnit;
  logic [TMO_W-1:0]  tmoCnt;
  logic              found, newHit, effFound;

  assign bitNow   = |(lenVec & (NUM_SEL'(1) << selIdx));
  assign unitLast = (unitIdx == {UNIT_W{1'b1}});
  assign selLast  = (selIdx == SEL_W'(NUM_SEL - 1));
  assign tmoHit   = (tmoCnt == TMO_W'(TMO_TICKS - 1));

  // A hit on the final step must be visible to the result pick in the same cycle
  assign newHit   = strb.recordHit && !found;
  assign effFound = found || newHit;
  assign effSel   = newHit ? selIdx + SEL_W'(1) : hitSel;
  assign effUnit  = newHit ? unitIdx : hitUnit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineEn <= 1'b0;  sampEn <= 1'b0;  cfgWr <= 1'b0;
      selOut <= '0;    unitOut <= '0;
      selIdx <= '0;    unitIdx <= '0;   tuning <= 1'b0;  found <= 1'b0;
      hitSel <= '0;    hitUnit <= '0;   applySel <= '0;  applyUnit <= '0;
      tmoCnt <= '0;    notFound <= 1'b0;
      calSel <= '0;    calUnit <= '0;
    end else begin
      cfgWr <= strb.progSweep | strb.progApply;
      if (strb.initSweep) begin
        lineEn <= 1'b1;  sampEn <= 1'b1;
        selIdx <= '0;    unitIdx <= '0;
        tuning <= 1'b0;  found <= 1'b0;
      end
      if (strb.ctlOff) begin lineEn <= 1'b0; sampEn <= 1'b0; end
      if (strb.ctlOn)  begin lineEn <= 1'b1; sampEn <= 1'b1; end
      if (strb.sampOff) sampEn <= 1'b0;
      if (strb.loadCfg) begin applySel <= cfgSel; applyUnit <= cfgUnit; end
      if (strb.progSweep) begin
        selOut  <= SEL_W'(NUM_SEL);
        unitOut <= unitIdx;
        tmoCnt  <= '0;
      end
      if (strb.tmoCount) tmoCnt <= tmoCnt + TMO_W'(1);
      if (strb.markHigh) tuning <= 1'b1;
      if (newHit) begin
        found   <= 1'b1;
        hitSel  <= effSel;
        hitUnit <= effUnit;
      end
      if (strb.stepUnit) unitIdx <= unitIdx + UNIT_W'(1);
      if (strb.stepSel) begin
        selIdx  <= selIdx + SEL_W'(1);
        unitIdx <= '0;
        tuning  <= 1'b0;
      end
      if (strb.pickResult) begin
        notFound  <= !effFound;
        calSel    <= effFound ? effSel  : '0;
        calUnit   <= effFound ? effUnit : '0;
        applySel  <= effFound ? effSel  : '0;
        applyUnit <= effFound ? effUnit : '0;
      end
      if (strb.progApply) begin
        selOut  <= applySel;
        unitOut <= applyUnit;
      end
    end
  end
endmodule

// File: rtl/dlcal_ctrl.sv
module dlcal_ctrl
  import dlcal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        startCal,
  input  logic        startCfg,
  input  logic        disableReq,
  input  logic        lenValid,
  input  logic        bitNow,
  input  logic        tuning,
  input  logic        unitLast,
  input  logic        selLast,
  input  logic        tmoHit,
  output dlcal_strb_t strb,
  output logic        busy,
  output logic        done,
  output logic        timeout
);
  dlcal_state_t state, stateNxt;
  logic busyNxt, doneNxt, tmoNxt, hit, endIdx;

  assign hit    = tuning && !bitNow;
  assign endIdx = hit || unitLast;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    busyNxt  = busy;
    doneNxt  = 1'b0;
    tmoNxt   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (disableReq) begin
          strb.ctlOff = 1'b1;
        end else if (startCal) begin
          strb.initSweep = 1'b1;
          busyNxt  = 1'b1;
          stateNxt = ST_PROG;
        end else if (startCfg) begin
          strb.loadCfg = 1'b1;
          busyNxt  = 1'b1;
          stateNxt = ST_OFF;
        end
      end
      ST_PROG: begin
        strb.progSweep = 1'b1;
        stateNxt = ST_SETTLE;
      end
      // one cycle for the line to drop its stale valid flag
      ST_SETTLE: stateNxt = ST_WAIT;
      ST_WAIT: begin
        if (lenValid) begin
          strb.markHigh  = !tuning && bitNow;
          strb.recordHit = hit;
          if (!endIdx) begin
            strb.stepUnit = 1'b1;
            stateNxt = ST_PROG;
          end else if (!selLast) begin
            strb.stepSel = 1'b1;
            stateNxt = ST_PROG;
          end else begin
            strb.pickResult = 1'b1;
            stateNxt = ST_OFF;
          end
        end else if (tick) begin
          if (tmoHit) begin
            tmoNxt   = 1'b1;
            busyNxt  = 1'b0;
            stateNxt = ST_IDLE;
          end else begin
            strb.tmoCount = 1'b1;
          end
        end
      end
      ST_OFF: begin strb.ctlOff    = 1'b1; stateNxt = ST_ON;   end
      ST_ON:  begin strb.ctlOn     = 1'b1; stateNxt = ST_WR;   end
      ST_WR:  begin strb.progApply = 1'b1; stateNxt = ST_DROP; end
      ST_DROP: begin
        strb.sampOff = 1'b1;
        doneNxt  = 1'b1;
        busyNxt  = 1'b0;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      state   <= stateNxt;
      busy    <= busyNxt;
      done    <= doneNxt;
      timeout <= tmoNxt;
    end
  end
endmodule

// File: rtl/dline_cal.sv
module dline_cal
  import dlcal_pkg::*;
#(
  parameter int NUM_SEL   = 12,
  parameter int UNIT_W    = 7,
  parameter int TMO_TICKS = 255
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick,
  input  logic                          startCal,
  input  logic                          startCfg,
  input  logic [$clog2(NUM_SEL+1)-1:0]  cfgSel,
  input  logic [UNIT_W-1:0]             cfgUnit,
  input  logic                          disableReq,
  input  logic                          lenValid,
  input  logic [NUM_SEL-1:0]            lenVec,
  output logic                          lineEn,
  output logic                          sampEn,
  output logic                          cfgWr,
  output logic [$clog2(NUM_SEL+1)-1:0]  selOut,
  output logic [UNIT_W-1:0]             unitOut,
  output logic                          busy,
  output logic                          done,
  output logic                          timeout,
  output logic                          notFound,
  output logic [$clog2(NUM_SEL+1)-1:0]  calSel,
  output logic [UNIT_W-1:0]             calUnit
);
  dlcal_strb_t strb;
  logic bitNow, tuning, unitLast, selLast, tmoHit;

  dlcal_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .startCal(startCal), .startCfg(startCfg), .disableReq(disableReq),
    .lenValid(lenValid), .bitNow(bitNow), .tuning(tuning),
    .unitLast(unitLast), .selLast(selLast), .tmoHit(tmoHit),
    .strb(strb), .busy(busy), .done(done), .timeout(timeout)
  );

  dlcal_dp #(.NUM_SEL(NUM_SEL), .UNIT_W(UNIT_W), .TMO_TICKS(TMO_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgSel(cfgSel), .cfgUnit(cfgUnit), .lenVec(lenVec),
    .bitNow(bitNow), .tuning(tuning), .unitLast(unitLast),
    .selLast(selLast), .tmoHit(tmoHit),
    .lineEn(lineEn), .sampEn(sampEn), .cfgWr(cfgWr),
    .selOut(selOut), .unitOut(unitOut),
    .notFound(notFound), .calSel(calSel), .calUnit(calUnit)
  );
endmodule

// File: rtl/dline_cal_chk.sv
module dline_cal_chk (
  input logic clk,
  input logic rstN,
  input logic startCal,
  input logic startCfg,
  input logic disableReq,
  input logic lineEn,
  input logic sampEn,
  input logic cfgWr,
  input logic busy,
  input logic done,
  input logic timeout
);
  p_wr_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |-> (sampEn && lineEn));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_state_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (lineEn && !sampEn && !busy));

  p_busy_src_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startCal || startCfg));

  p_end_flags_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, timeout}));

  p_tmo_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> !busy);

  p_disable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && disableReq) |=> (!lineEn && !sampEn));
endmodule

bind dline_cal dline_cal_chk u_chk (
  .clk(clk), .rstN(rstN), .startCal(startCal), .startCfg(startCfg),
  .disableReq(disableReq), .lineEn(lineEn), .sampEn(sampEn),
  .cfgWr(cfgWr), .busy(busy), .done(done), .timeout(timeout)
);

// File: tb/dline_cal_tb.sv
module dline_cal_tb;
  localparam int NS   = 4;
  localparam int UW   = 5;
  localparam int TMO  = 16;
  localparam int SW   = $clog2(NS + 1);
  localparam int UMAX = (1 << UW) - 1;
  localparam int LOGN = 200;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b1;
  logic startCal = 1'b0, startCfg = 1'b0, disableReq = 1'b0;
  logic [SW-1:0] cfgSel = '0;
  logic [UW-1:0] cfgUnit = '0;
  logic lenValid;
  logic [NS-1:0] lenVec;
  logic lineEn, sampEn, cfgWr, busy, done, timeout, notFound;
  logic [SW-1:0] selOut, calSel;
  logic [UW-1:0] unitOut, calUnit;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dline_cal #(.NUM_SEL(NS), .UNIT_W(UW), .TMO_TICKS(TMO)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .startCal(startCal), .startCfg(startCfg),
    .cfgSel(cfgSel), .cfgUnit(cfgUnit), .disableReq(disableReq),
    .lenValid(lenValid), .lenVec(lenVec), .lineEn(lineEn), .sampEn(sampEn),
    .cfgWr(cfgWr), .selOut(selOut), .unitOut(unitOut), .busy(busy), .done(done),
    .timeout(timeout), .notFound(notFound), .calSel(calSel), .calUnit(calUnit)
  );

  // ---------------- behavioural delay line ----------------
  int hiAt[NS];
  int loAt[NS];
  int modelLat = 3;
  bit stall = 0;
  int latCnt;

  function automatic logic [NS-1:0] lineSample(int u);
    logic [NS-1:0] v;
    for (int k = 0; k < NS; k++) v[k] = (u >= hiAt[k]) && (u < loAt[k]);
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenValid <= 1'b0; lenVec <= '0; latCnt <= 0;
    end else if (cfgWr) begin
      lenValid <= 1'b0; latCnt <= modelLat;
    end else if (!lenValid && !stall && latCnt != 0) begin
      latCnt <= latCnt - 1;
      if (latCnt == 1) begin
        lenValid <= 1'b1;
        lenVec   <= lineSample(int'(unitOut));
      end
    end
  end

  // ---------------- monitor ----------------
  int logSel[LOGN];
  int logUnit[LOGN];
  int nWr = 0, gateBad = 0, busyGap = 0;
  bit sawOff = 0, prevBusy = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (cfgWr) begin
        if (nWr < LOGN) begin logSel[nWr] = int'(selOut); logUnit[nWr] = int'(unitOut); end
        nWr++;
        if (!(sampEn && lineEn)) gateBad++;
      end
      if (busy && !lineEn && !sampEn) sawOff = 1;
      if (prevBusy && !busy && !done && !timeout) busyGap++;
      prevBusy = busy;
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic waitEnd(output int c);
    c = 0;
    while (!(done || timeout) && c < 20000) begin @(negedge clk); c++; end
  endtask

  int expSel[LOGN];
  int expUnit[LOGN];
  int nExp, eSel, eUnit;
  bit eFound;

  // Expected sweep from the requirements (R3, R5, R6, R13)
  task automatic buildExp();
    nExp = 0; eFound = 0; eSel = 0; eUnit = 0;
    for (int k = 0; k < NS; k++) begin
      bit tun = 0;
      for (int u = 0; u <= UMAX; u++) begin
        bit b = (u >= hiAt[k]) && (u < loAt[k]);
        expSel[nExp] = NS; expUnit[nExp] = u; nExp++;
        if (!tun) begin
          if (b) tun = 1;
        end else if (!b) begin
          if (!eFound) begin eFound = 1; eSel = k + 1; eUnit = u; end
          break;
        end
      end
    end
    expSel[nExp] = eFound ? eSel : 0;
    expUnit[nExp] = eFound ? eUnit : 0;
    nExp++;
  endtask

  task automatic cmpLog(string req);
    int firstBad = -1;
    for (int i = 0; i < nExp && i < LOGN; i++)
      if (firstBad < 0 && (logSel[i] != expSel[i] || logUnit[i] != expUnit[i])) firstBad = i;
    chk(nWr == nExp, req, nWr, nExp);
    if (firstBad >= 0)
      chk(0, req, logSel[firstBad] * 1000 + logUnit[firstBad],
          expSel[firstBad] * 1000 + expUnit[firstBad]);
    else
      chk(1, req, 0, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    @(negedge clk);
    chk({lineEn, sampEn, cfgWr, busy, done, timeout, notFound} == '0, "R1 flags",
        int'({lineEn, sampEn, cfgWr, busy, done, timeout, notFound}), 0);
    chk(selOut == '0 && unitOut == '0, "R1 fields", int'(selOut) * 1000 + int'(unitOut), 0);
  endtask

  task automatic testCalibrate();
    int c;
    hiAt = '{3, 2, 40, 0};
    loAt = '{9, 5, 41, 40};
    modelLat = 3; stall = 0; tick = 1;
    buildExp();
    nWr = 0; sawOff = 0; busyGap = 0;
    pulse(startCal);
    chk(busy && lineEn && sampEn, "R2 start", int'({busy, lineEn, sampEn}), 7);
    repeat (40) @(negedge clk);
    // R11: starts while busy must be ignored
    cfgSel = 3'd2; cfgUnit = 5'd7;
    pulse(startCfg);
    pulse(startCal);
    waitEnd(c);
    chk(done && !timeout, "R7 done", int'({done, timeout}), 2);
    cmpLog("R3 R5 R13 sweep");
    chk(calSel == SW'(eSel) && calUnit == UW'(eUnit), "R6 first hit kept",
        int'(calSel) * 1000 + int'(calUnit), eSel * 1000 + eUnit);
    chk(eSel == 1 && eUnit == 9, "R6 model hit", eSel * 1000 + eUnit, 1009);
    chk(!notFound, "R12 found", int'(notFound), 0);
    chk(lineEn && !sampEn && selOut == 3'd1 && unitOut == 5'd9 && sawOff,
        "R7 apply", int'({lineEn, sampEn, sawOff}) * 1000 + int'(unitOut), 5009);
    chk(busyGap == 0 && !busy, "R11 busy span", busyGap, 0);
    @(negedge clk);
    chk(!done, "R7 done pulse", int'(done), 0);
    chk(gateBad == 0, "R8 gating", gateBad, 0);
  endtask

  task automatic testNotFound();
    int c;
    hiAt = '{40, 40, 0, 40};
    loAt = '{41, 41, 40, 41};
    buildExp();
    nWr = 0;
    pulse(startCal);
    waitEnd(c);
    cmpLog("R12 R13 sweep");
    chk(notFound && calSel == '0 && calUnit == '0, "R12 status",
        int'(notFound) * 1000 + int'(calSel) * 100 + int'(calUnit), 1000);
    chk(selOut == '0 && unitOut == '0 && lineEn && !sampEn, "R12 applied",
        int'(selOut) * 100 + int'(unitOut), 0);
  endtask

  task automatic testDirect();
    int c;
    nWr = 0; sawOff = 0;
    cfgSel = 3'd3; cfgUnit = 5'd17;
    pulse(startCfg);
    chk(busy, "R9 busy", int'(busy), 1);
    waitEnd(c);
    chk(done && nWr == 1, "R9 single write", nWr, 1);
    chk(selOut == 3'd3 && unitOut == 5'd17 && sawOff, "R9 applied",
        int'(selOut) * 100 + int'(unitOut), 317);
    chk(notFound && calSel == '0 && calUnit == '0, "R9 result untouched",
        int'(notFound) * 1000 + int'(calSel) * 100 + int'(calUnit), 1000);
  endtask

  task automatic testDisable();
    nWr = 0;
    @(negedge clk) begin disableReq = 1'b1; startCal = 1'b1; end
    @(negedge clk) begin disableReq = 1'b0; startCal = 1'b0; end
    chk(!lineEn && !sampEn && !busy, "R10 disable wins",
        int'({lineEn, sampEn, busy}), 0);
    repeat (3) @(negedge clk);
    chk(nWr == 0 && selOut == 3'd3, "R10 no write", nWr, 0);
  endtask

  task automatic testTimeout();
    int c;
    stall = 1; tick = 1;
    pulse(startCal);
    waitEnd(c);
    chk(timeout && !done && !busy, "R4 timeout", int'({timeout, done, busy}), 4);
    chk(c >= TMO && c <= TMO + 3, "R4 budget", c, TMO + 2);
    @(negedge clk);
    chk(!timeout, "R4 timeout pulse", int'(timeout), 0);
    stall = 0;
  endtask

  task automatic testTickGate();
    int c;
    hiAt = '{0, 0, 0, 0};
    loAt = '{1, 1, 1, 1};
    stall = 1; tick = 0;
    pulse(startCal);
    repeat (100) @(negedge clk);
    chk(busy && !timeout, "R4 ticks only", int'({busy, timeout}), 2);
    stall = 0; tick = 1;
    waitEnd(c);
    chk(done && calSel == 3'd1 && calUnit == 5'd1, "R4 resume",
        int'(calSel) * 100 + int'(calUnit), 101);
  endtask

  task automatic testSlowLine();
    int c;
    hiAt = '{40, 1, 40, 40};
    loAt = '{41, 3, 41, 41};
    modelLat = TMO - 4;
    pulse(startCal);
    waitEnd(c);
    chk(done && !timeout && calSel == 3'd2 && calUnit == 5'd3, "R4 R6 slow line",
        int'(timeout) * 1000 + int'(calSel) * 100 + int'(calUnit), 203);
    modelLat = 3;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk) rstN = 1'b1;
    testCalibrate();
    testNotFound();
    testDirect();
    testDisable();
    testTimeout();
    testTickGate();
    testSlowLine();
    chk(gateBad == 0, "R8 gating overall", gateBad, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule